// File: doc/BRIEF.md
# Conversion-Triggered Serial Readout Master

This block is the host-side controller for a converter that delivers two results over a serial link. A one-cycle trigger starts a transaction. The block drives an active-low convert-start pulse and then watches the converter's busy line. After busy has been seen high and then low, the block pulls an active-low frame select and issues a counted burst of serial clocks. The frame select also acts as the converter's chip-select. The controller captures the incoming bits and presents the two results right-justified in 14-bit registers, together with a one-cycle done strobe.

The read can use two data lines at once, with result A on one line and result B on the other. It can also use one line, where B follows A in a single chained stream. In the chained case the bits that sit between the two results are discarded. Configuration inputs set the clock divider, the result width (12 or 14 bits), the lane mode, an optional 16-clock word in dual-line mode, and the length of the convert pulse. All of them are latched when the trigger is accepted. If busy never completes, a timeout strobe ends the transaction without a frame.

Top module: `conv_readout_master`

## Requirements
- R1: After reset, cnv_n, cs_n and sclk are 1, done and timeout are 0, and res_a and res_b are 0.
- R2: A trigger accepted in idle drives cnv_n low from the next clock edge for cfg_pulse cycles. A cfg_pulse of 0 gives one cycle.
- R3: cs_n falls at the first clock edge at which busy is sampled low after it was sampled high during the wait, and never while cnv_n is low.
- R4: sclk idles high and only goes low inside a frame. The first sclk fall comes cfg_div+1 cycles after cs_n falls, and every half period lasts cfg_div+1 cycles. Data is sampled when sclk rises.
- R5: In dual-line mode (cfg_single=0), W clocks are issued, where W is 14 if cfg_wide=1 and 12 otherwise. With cfg_word16=1, 16 clocks are issued instead. The first W bits on dina form res_a and those on dinb form res_b, MSB first, right-justified with the upper bits zero. Bits after the first W are ignored.
- R6: In single-line mode (cfg_single=1), 14+W clocks are issued on dina and cfg_word16 is ignored. Bits 0..W-1 form res_a, bits W..13 are discarded whatever their value, and bits 14..13+W form res_b.
- R7: cs_n rises one half period after the last sclk rise. In that same cycle done pulses for exactly one cycle, and res_a and res_b take the new values.
- R8: A trigger that arrives while a conversion, wait or read is in progress is dropped and starts no extra cnv_n pulse.
- R9: If busy has not completed within TMO_CYC cycles of cnv_n returning high, timeout pulses for one cycle exactly TMO_CYC cycles later. No frame is issued, the results keep their values, and the block returns to idle.
- R10: cfg_div, cfg_wide, cfg_single, cfg_word16 and cfg_pulse are latched when the trigger is accepted. Changes during the transaction do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Start request, one cycle |
| cfg_div | input | DIV_W | Half-period of sclk minus one, in clk cycles |
| cfg_pulse | input | PULSE_W | Convert pulse length in cycles (0 means 1) |
| cfg_wide | input | 1 | 1: 14-bit results, 0: 12-bit results |
| cfg_single | input | 1 | 1: chained stream on dina, 0: dual lines |
| cfg_word16 | input | 1 | Dual-line mode: issue 16 clocks per frame |
| busy | input | 1 | Converter busy, high during conversion |
| dina | input | 1 | Serial data line A |
| dinb | input | 1 | Serial data line B |
| cnv_n | output | 1 | Convert-start, active low |
| cs_n | output | 1 | Frame select / chip-select, active low |
| sclk | output | 1 | Serial clock, idles high |
| res_a | output | 14 | Result A, right-justified |
| res_b | output | 14 | Result B, right-justified |
| done | output | 1 | One-cycle strobe, new results |
| timeout | output | 1 | One-cycle strobe, busy never completed |

## Verification
The in-line assertions check the following on every cycle:
- sclk never leaves its idle level outside a frame, and every frame opens with sclk high.
- A frame never overlaps the convert pulse and only starts once busy is low.
- Convert pulses start only from idle, so a trigger during a transaction cannot start a second pulse.
- The number of sclk rises in each frame matches the latched mode.
- done comes with the closing frame edge and lasts one cycle, and it never coincides with timeout.

Only the bench scenarios show the data path and the timing counts. Those scenarios cover:
- bit ordering, right-justification and zero-extension;
- discarding of the inter-result padding, which the bench model drives as ones;
- the exact half-period lengths, the convert pulse length and the timeout distance;
- configuration changes in the middle of a transaction having no effect.

// File: rtl/conv_readout_master.sv
module conv_readout_master #(
  parameter int DIV_W   = 4,
  parameter int PULSE_W = 4,
  parameter int TMO_CYC = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [PULSE_W-1:0] cfg_pulse,
  input  logic               cfg_wide,
  input  logic               cfg_single,
  input  logic               cfg_word16,
  input  logic               busy,
  input  logic               dina,
  input  logic               dinb,
  output logic               cnv_n,
  output logic               cs_n,
  output logic               sclk,
  output logic [13:0]        res_a,
  output logic [13:0]        res_b,
  output logic               done,
  output logic               timeout
);

  localparam int RES_W   = 14;
  localparam int SHORT_W = 12;
  localparam int WORD_W  = 16;
  localparam int CNT_W   = $clog2(2 * RES_W + 1);
  localparam int TMO_W   = $clog2(TMO_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_CNV, S_WAIT, S_READ} state_t;

  state_t             state;
  logic [DIV_W-1:0]   div_q, hc;
  logic [PULSE_W-1:0] plen_q, pcnt;
  logic               wide_q, single_q, w16_q;
  logic [TMO_W-1:0]   tmo;
  logic               seen_hi;
  logic [CNT_W-1:0]   edges;
  logic [RES_W-1:0]   sha, shb;

  wire [CNT_W-1:0] w_bits = wide_q ? CNT_W'(RES_W) : CNT_W'(SHORT_W);
  wire [CNT_W-1:0] n_clk  = single_q ? CNT_W'(RES_W) + w_bits
                                     : (w16_q ? CNT_W'(WORD_W) : w_bits);
  wire             half_done = (hc == div_q);
  wire             take_a    = (edges < w_bits);
  wire             take_b    = single_q ? (edges >= CNT_W'(RES_W)) : take_a;
  wire             b_src     = single_q ? dina : dinb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      div_q    <= '0;
      hc       <= '0;
      plen_q   <= PULSE_W'(1);
      pcnt     <= '0;
      wide_q   <= 1'b0;
      single_q <= 1'b0;
      w16_q    <= 1'b0;
      tmo      <= '0;
      seen_hi  <= 1'b0;
      edges    <= '0;
      sha      <= '0;
      shb      <= '0;
      cnv_n    <= 1'b1;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      res_a    <= '0;
      res_b    <= '0;
      done     <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      case (state)
        S_IDLE: begin
          if (trig) begin
            div_q    <= cfg_div;
            plen_q   <= (cfg_pulse == '0) ? PULSE_W'(1) : cfg_pulse;
            wide_q   <= cfg_wide;
            single_q <= cfg_single;
            w16_q    <= cfg_word16;
            pcnt     <= '0;
            cnv_n    <= 1'b0;
            state    <= S_CNV;
          end
        end
        S_CNV: begin
          if (pcnt == plen_q - PULSE_W'(1)) begin
            cnv_n   <= 1'b1;
            tmo     <= '0;
            seen_hi <= 1'b0;
            state   <= S_WAIT;
          end else begin
            pcnt <= pcnt + PULSE_W'(1);
          end
        end
        S_WAIT: begin
          if (seen_hi && !busy) begin
            cs_n  <= 1'b0;
            sclk  <= 1'b1;
            hc    <= '0;
            edges <= '0;
            sha   <= '0;
            shb   <= '0;
            state <= S_READ;
          end else if (tmo == TMO_W'(TMO_CYC - 1)) begin
            timeout <= 1'b1;
            state   <= S_IDLE;
          end else begin
            tmo <= tmo + TMO_W'(1);
            if (busy) seen_hi <= 1'b1;
          end
        end
        S_READ: begin
          if (!half_done) begin
            hc <= hc + DIV_W'(1);
          end else begin
            hc <= '0;
            if (sclk) begin
              if (edges == n_clk) begin
                cs_n  <= 1'b1;
                done  <= 1'b1;
                res_a <= sha;
                res_b <= shb;
                state <= S_IDLE;
              end else begin
                sclk <= 1'b0;
              end
            end else begin
              sclk  <= 1'b1;
              edges <= edges + CNT_W'(1);
              if (take_a) sha <= {sha[RES_W-2:0], dina};
              if (take_b) shb <= {shb[RES_W-2:0], b_src};
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic             sclk_d;
  logic [CNT_W-1:0] chk_rises;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d    <= 1'b1;
      chk_rises <= '0;
    end else begin
      sclk_d <= sclk;
      if (cs_n)
        chk_rises <= '0;
      else if (sclk && !sclk_d)
        chk_rises <= chk_rises + CNT_W'(1);
    end
  end

  a_r2_cnv_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n) |-> ($past(trig) && $past(state == S_IDLE)));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && state != S_IDLE) |=> !$fell(cnv_n));

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_n |-> cs_n);

  a_r3_after_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(busy));

  a_r4_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> !cs_n);

  a_r4_frame_opens_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> sclk);

  a_r5_clock_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (chk_rises == n_clk));

  a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_timeout_clean: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (cs_n && !done));

endmodule

// File: tb/conv_readout_master_bench.sv
`timescale 1ns/1ps
module conv_readout_master_bench;
  localparam int DIV_W = 4, PULSE_W = 4, TMO = 64;

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [PULSE_W-1:0] cfg_pulse = '0;
  logic cfg_wide = 1'b0, cfg_single = 1'b0, cfg_word16 = 1'b0;
  logic busy = 1'b0;
  logic dina, dinb, cnv_n, cs_n, sclk, done, timeout;
  logic [13:0] res_a, res_b;

  logic [13:0] dev_a = '0, dev_b = '0;
  logic dev_wide = 1'b0, dev_single = 1'b0, dev_respond = 1'b1;
  int fcnt = 0, rises = 0, cnv_falls = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  conv_readout_master #(.DIV_W(DIV_W), .PULSE_W(PULSE_W), .TMO_CYC(TMO)) u_conv_readout_master (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_div(cfg_div), .cfg_pulse(cfg_pulse),
    .cfg_wide(cfg_wide), .cfg_single(cfg_single), .cfg_word16(cfg_word16),
    .busy(busy), .dina(dina), .dinb(dinb), .cnv_n(cnv_n), .cs_n(cs_n), .sclk(sclk),
    .res_a(res_a), .res_b(res_b), .done(done), .timeout(timeout));

  always #2 clk = ~clk;

  function automatic logic dev_bit(input logic lane_b, input int k, input logic [13:0] a,
                                   input logic [13:0] b, input logic wide, input logic single);
    int w;
    w = wide ? 14 : 12;
    if (!single) begin
      if (k < w) return lane_b ? b[w-1-k] : a[w-1-k];
      return 1'b1;
    end
    if (lane_b) return 1'b0;
    if (k < w) return a[w-1-k];
    if (k < 14) return 1'b1;
    if (k < 14 + w) return b[w-1-(k-14)];
    return 1'b1;
  endfunction

  assign dina = dev_bit(1'b0, (fcnt == 0) ? 0 : fcnt - 1, dev_a, dev_b, dev_wide, dev_single);
  assign dinb = dev_bit(1'b1, (fcnt == 0) ? 0 : fcnt - 1, dev_a, dev_b, dev_wide, dev_single);

  always @(posedge cs_n, negedge sclk) begin
    if (cs_n) fcnt = 0;
    else fcnt = fcnt + 1;
  end
  always @(posedge sclk) if (!cs_n) rises = rises + 1;
  always @(negedge cnv_n) cnv_falls = cnv_falls + 1;

  always begin
    @(negedge cnv_n);
    if (dev_respond) begin
      repeat (2) @(negedge clk);
      #1 busy = 1'b1;
      repeat (12) @(negedge clk);
      #1 busy = 1'b0;
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic single, input logic wide, input logic w16,
                       input logic [3:0] div, input logic [3:0] pulse,
                       input logic [13:0] a, input logic [13:0] b);
    cfg_single = single; cfg_wide = wide; cfg_word16 = w16;
    cfg_div = div; cfg_pulse = pulse;
    dev_a = a; dev_b = b; dev_wide = wide; dev_single = single;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 4000; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input logic single, input logic wide, input logic w16,
                           input logic [3:0] div, input logic [3:0] pulse,
                           input logic [13:0] a, input logic [13:0] b);
    int w, n, r0, low, expl;
    bit seen, pb, pcs;
    logic [13:0] ea, eb;
    string rq;
    w = wide ? 14 : 12;
    n = single ? 14 + w : (w16 ? 16 : w);
    ea = a & ((14'd1 << w) - 14'd1);
    eb = b & ((14'd1 << w) - 14'd1);
    expl = (pulse == 0) ? 1 : int'(pulse);
    rq = single ? "R6" : "R5";
    @(negedge clk);
    setup(single, wide, w16, div, pulse, a, b);
    r0 = rises; low = 0; seen = 0; pb = busy; pcs = cs_n;
    pulse_trig();
    for (int i = 0; i < 4000; i++) begin
      if (!cnv_n) low++;
      if (pb && !busy) check("R3", (cs_n == 1'b0) && pcs, int'(cs_n), 0);
      if (done) begin seen = 1; break; end
      pb = busy; pcs = cs_n;
      @(negedge clk);
    end
    check("R7", seen, int'(seen), 1);
    check("R7", cs_n == 1'b1, int'(cs_n), 1);
    check("R2", low == expl, low, expl);
    check(rq, res_a == ea, int'(res_a), int'(ea));
    check(rq, res_b == eb, int'(res_b), int'(eb));
    check(rq, (rises - r0) == n, rises - r0, n);
    @(negedge clk);
    check("R7", done == 1'b0, int'(done), 0);
  endtask

  typedef struct packed {
    logic single, wide, w16;
    logic [3:0] div, pulse;
    logic [13:0] a, b;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{1'b0, 1'b0, 1'b0, 4'd0,  4'd1, 14'h0ABC, 14'h0543},
    '{1'b0, 1'b1, 1'b0, 4'd1,  4'd3, 14'h2D3A, 14'h15C7},
    '{1'b0, 1'b0, 1'b1, 4'd2,  4'd0, 14'h3FFF, 14'h0001},
    '{1'b0, 1'b1, 1'b1, 4'd0,  4'd2, 14'h3001, 14'h0FFE},
    '{1'b1, 1'b0, 1'b0, 4'd0,  4'd1, 14'h0A5C, 14'h035A},
    '{1'b1, 1'b1, 1'b0, 4'd3,  4'd5, 14'h3E01, 14'h01F0},
    '{1'b1, 1'b0, 1'b1, 4'd1,  4'd0, 14'h0FFF, 14'h0800},
    '{1'b0, 1'b0, 1'b0, 4'd15, 4'd1, 14'h0000, 14'h0FFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k, c0, r0;
    bit seen;
    logic [13:0] ka, kb;
    repeat (3) @(negedge clk);
    check("R1", cnv_n && cs_n && sclk, int'({cnv_n, cs_n, sclk}), 7);
    check("R1", !done && !timeout, int'({done, timeout}), 0);
    check("R1", res_a == 0 && res_b == 0, int'(res_a), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++)
      run_frame(VEC[i].single, VEC[i].wide, VEC[i].w16, VEC[i].div, VEC[i].pulse,
                VEC[i].a, VEC[i].b);

    // R4: half-period lengths with divider 5
    setup(1'b0, 1'b0, 1'b0, 4'd5, 4'd1, 14'h0123, 14'h0456);
    pulse_trig();
    while (cs_n) @(negedge clk);
    k = 0;
    while (sclk) begin @(negedge clk); k++; end
    check("R4", k == 6, k, 6);
    k = 0;
    while (!sclk) begin @(negedge clk); k++; end
    check("R4", k == 6, k, 6);
    wait_done(seen);
    check("R4", seen && res_a == 14'h0123 && res_b == 14'h0456, int'(res_a), 'h123);
    @(negedge clk);

    // R8: trigger during a read is dropped
    setup(1'b0, 1'b1, 1'b0, 4'd1, 4'd1, 14'h1111, 14'h2222);
    c0 = cnv_falls;
    pulse_trig();
    while (cs_n) @(negedge clk);
    pulse_trig();
    wait_done(seen);
    repeat (40) @(negedge clk);
    check("R8", (cnv_falls - c0) == 1, cnv_falls - c0, 1);
    check("R8", cs_n == 1'b1, int'(cs_n), 1);

    // R10: configuration changed mid-transaction has no effect
    setup(1'b0, 1'b0, 1'b0, 4'd1, 4'd1, 14'h0F0F, 14'h0A0A);
    r0 = rises;
    pulse_trig();
    while (cs_n) @(negedge clk);
    cfg_single = 1'b1; cfg_wide = 1'b1; cfg_div = 4'd0; cfg_word16 = 1'b1;
    wait_done(seen);
    check("R10", seen && res_a == 14'h0F0F, int'(res_a), 'hF0F);
    check("R10", res_b == 14'h0A0A, int'(res_b), 'hA0A);
    check("R10", (rises - r0) == 12, rises - r0, 12);
    @(negedge clk);

    // R9: busy never completes
    ka = res_a; kb = res_b;
    dev_respond = 1'b0;
    setup(1'b0, 1'b0, 1'b0, 4'd0, 4'd1, 14'h0777, 14'h0333);
    dev_respond = 1'b0;
    r0 = rises;
    pulse_trig();
    while (!cnv_n) @(negedge clk);
    k = 0;
    while (!timeout && k < 1000) begin
      check("R9", cs_n == 1'b1 && !done, int'(cs_n), 1);
      @(negedge clk); k++;
    end
    check("R9", k == TMO, k, TMO);
    check("R9", res_a == ka && res_b == kb, int'(res_a), int'(ka));
    check("R9", rises == r0, rises, r0);
    @(negedge clk);
    check("R9", timeout == 1'b0, int'(timeout), 0);
    dev_respond = 1'b1;
    run_frame(1'b1, 1'b0, 1'b0, 4'd0, 4'd1, 14'h0C3C, 14'h03C3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule